// File: doc/BRIEF.md
# PWM Fault Shutdown Controller

This block sits between a multi-channel PWM generator and the output pads. While any fault input is high, it forces every PWM output to a programmable off-level. The forcing path is purely combinational, so it acts even when the system clock has stopped. Each fault source has a sticky flag that software can read and clear with a write-one strobe.

A shutdown is latched at once by the fault itself, with no clock involved. It is released only by clocked restart logic, in one of two ways. In automatic mode the outputs come back at the first PWM period start (the master counter is at zero) with no fault present. In software mode they come back once every fault is low and software has cleared every flag. Channels are grouped in pairs, and each pair has its own output-enable. The level present on each pad can be read back: the driven value when the pair is enabled, and the external pad level when it is not.

Top module: `pwm_fault_guard`

## Requirements
- R1: While any bit of `fault_in` is 1, every `pin_val` bit equals its `off_val` bit within the same time step, with no clock edge needed.
- R2: When not shut down, `pin_val[c]` equals `pwm_in[c]`; when shut down, `pin_val[c]` equals `off_val[c]`, and the off-level is chosen per channel.
- R3: Pair p drives channels 2p and 2p+1; `pin_oe` of both channels equals `pair_en[p]` (1 = driven, 0 = high impedance).
- R4: `pin_rd[c]` equals `pin_val[c]` when `pin_oe[c]` is 1, and equals `pad_in[c]` otherwise.
- R5: `fault_flags[i]` becomes 1 after a rising clock edge that samples `fault_in[i]` high, and stays 1 after the fault goes low.
- R6: A 1 on `flag_clr[i]` at a clock edge clears `fault_flags[i]` only if `fault_in[i]` is low at that edge; while the fault is high the clear is ignored.
- R7: With `sw_restart`=0, a latched shutdown persists until a clock edge that samples `cnt_zero`=1 and all faults low; the pins then follow `pwm_in`.
- R8: With `sw_restart`=1, a latched shutdown is released at the first clock edge that samples all faults low and all flags zero; `cnt_zero` has no effect.
- R9: A fault that rises and falls while the clock is stopped leaves the outputs forced until the restart logic releases them after the clock resumes.
- R10: After reset, all flags are 0, no shutdown is latched and the pins follow `pwm_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | NCH | Raw channel values from the PWM generator |
| fault_in | input | NFLT | Fault sources, active high |
| cnt_zero | input | 1 | Master counter is at zero (period start) |
| sw_restart | input | 1 | 1 = software restart, 0 = automatic restart |
| flag_clr | input | NFLT | Write-one strobe clearing the fault flags |
| pair_en | input | NPAIRS | Output enable per channel pair |
| off_val | input | NCH | Off-level per channel |
| pad_in | input | NCH | Level seen at each pad |
| pin_val | output | NCH | Value driven to each pad |
| pin_oe | output | NCH | Output enable per pad |
| pin_rd | output | NCH | Readback of the pad levels |
| fault_flags | output | NFLT | Sticky fault flags |

## Verification
The hardest case to reach from the ports is a fault that both rises and falls while the clock is stopped. The bench stops its own clock generator while the clock is low, toggles a fault, and checks the forced outputs with no edge in between. It then restarts the clock with the counter-zero input held low and checks that the shutdown survives until a period start. The software restart sequence is driven one edge at a time, so the bench can see that the release lands one edge after the flags clear.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  // Release decision of the restart logic
  function automatic logic release_ok(input logic sw_mode, input logic zero_hit,
                                      input logic any_fault, input logic any_flag);
    if (any_fault) return 1'b0;
    return sw_mode ? !any_flag : zero_hit;
  endfunction

  // Next state of one sticky flag: set wins over clear
  function automatic logic next_flag(input logic cur, input logic src, input logic clr);
    return src | (cur & ~clr);
  endfunction
endpackage

// File: rtl/pfg_flags.sv
module pfg_flags #(
  parameter int NFLT = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NFLT-1:0] fault_in,
  input  logic [NFLT-1:0] flag_clr,
  output logic [NFLT-1:0] flags
);
  import pfg_pkg::*;

  for (genvar i = 0; i < NFLT; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= next_flag(flags[i], fault_in[i], flag_clr[i]);
    end

    // R5
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_in[i] |=> flags[i]);
    // R6
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!fault_in[i] && flag_clr[i]) |=> !flags[i]);
  end
endmodule

// File: rtl/pfg_restart.sv
module pfg_restart (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_any,
  input  logic sw_mode,
  input  logic cnt_zero,
  input  logic flags_any,
  output logic shut_q
);
  import pfg_pkg::*;

  logic release_evt;
  assign release_evt = shut_q && release_ok(sw_mode, cnt_zero, fault_any, flags_any);

  // Set directly by the fault, cleared only on a clock edge
  always_ff @(posedge clk or negedge rst_n or posedge fault_any) begin
    if (!rst_n)         shut_q <= 1'b0;
    else if (fault_any) shut_q <= 1'b1;
    else if (release_evt) shut_q <= 1'b0;
  end

  // R7
  auto_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shut_q && !sw_mode && !cnt_zero) |=> shut_q);
  // R8
  sw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shut_q && sw_mode && flags_any) |=> shut_q);
  // R1
  fault_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_any |=> shut_q);
endmodule

// File: rtl/pfg_pins.sv
module pfg_pins #(
  parameter int NPAIRS = 3,
  localparam int NCH = 2 * NPAIRS
) (
  input  logic [NCH-1:0]    pwm_in,
  input  logic [NCH-1:0]    off_val,
  input  logic              force_off,
  input  logic [NPAIRS-1:0] pair_en,
  input  logic [NCH-1:0]    pad_in,
  output logic [NCH-1:0]    pin_val,
  output logic [NCH-1:0]    pin_oe,
  output logic [NCH-1:0]    pin_rd
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign pin_val[c] = force_off ? off_val[c] : pwm_in[c];
    assign pin_oe[c]  = pair_en[c/2];
    assign pin_rd[c]  = pin_oe[c] ? pin_val[c] : pad_in[c];
  end
endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard #(
  parameter int NPAIRS = 3,
  parameter int NFLT   = 2,
  localparam int NCH   = 2 * NPAIRS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    pwm_in,
  input  logic [NFLT-1:0]   fault_in,
  input  logic              cnt_zero,
  input  logic              sw_restart,
  input  logic [NFLT-1:0]   flag_clr,
  input  logic [NPAIRS-1:0] pair_en,
  input  logic [NCH-1:0]    off_val,
  input  logic [NCH-1:0]    pad_in,
  output logic [NCH-1:0]    pin_val,
  output logic [NCH-1:0]    pin_oe,
  output logic [NCH-1:0]    pin_rd,
  output logic [NFLT-1:0]   fault_flags
);
  logic fault_any, flags_any, shut_q, force_off;

  assign fault_any = |fault_in;
  assign flags_any = |fault_flags;
  assign force_off = fault_any | shut_q;

  pfg_flags #(.NFLT(NFLT)) u_flags (
    .clk(clk), .rst_n(rst_n), .fault_in(fault_in),
    .flag_clr(flag_clr), .flags(fault_flags)
  );

  pfg_restart u_restart (
    .clk(clk), .rst_n(rst_n), .fault_any(fault_any), .sw_mode(sw_restart),
    .cnt_zero(cnt_zero), .flags_any(flags_any), .shut_q(shut_q)
  );

  pfg_pins #(.NPAIRS(NPAIRS)) u_pins (
    .pwm_in(pwm_in), .off_val(off_val), .force_off(force_off),
    .pair_en(pair_en), .pad_in(pad_in),
    .pin_val(pin_val), .pin_oe(pin_oe), .pin_rd(pin_rd)
  );

  // R1
  always_comb begin
    if (fault_any) off_level_chk: assert (pin_val == off_val);
  end
endmodule

// File: tb/pwm_fault_guard_bench.sv
module pwm_fault_guard_bench;
  localparam int NP = 3, NF = 2, NC = 6;

  typedef struct packed {
    logic [1:0] f; logic [5:0] pwm; logic [5:0] off;
    logic [2:0] en; logic [5:0] pad; logic forced;
  } vec_t;

  localparam vec_t TBL [6] = '{
    '{2'b00, 6'b101010, 6'b000000, 3'b111, 6'b000000, 1'b0},
    '{2'b00, 6'b010101, 6'b111111, 3'b101, 6'b110011, 1'b0},
    '{2'b00, 6'b111000, 6'b000111, 3'b010, 6'b101010, 1'b0},
    '{2'b01, 6'b111000, 6'b000111, 3'b111, 6'b000000, 1'b1},
    '{2'b00, 6'b101101, 6'b110000, 3'b011, 6'b010101, 1'b1},
    '{2'b10, 6'b000000, 6'b101010, 3'b110, 6'b111111, 1'b1}
  };

  logic clk = 0, clk_run = 1, rst_n = 0;
  logic [NC-1:0] pwm_in = '0, off_val = '0, pad_in = '0;
  logic [NF-1:0] fault_in = '0, flag_clr = '0;
  logic cnt_zero = 0, sw_restart = 0;
  logic [NP-1:0] pair_en = '0;
  logic [NC-1:0] pin_val, pin_oe, pin_rd;
  logic [NF-1:0] fault_flags;
  int checks = 0, fails = 0;
  bit done = 0;

  always begin #4; if (clk_run) clk = ~clk; end

  pwm_fault_guard #(.NPAIRS(NP), .NFLT(NF)) u_pwm_fault_guard (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .fault_in(fault_in),
    .cnt_zero(cnt_zero), .sw_restart(sw_restart), .flag_clr(flag_clr),
    .pair_en(pair_en), .off_val(off_val), .pad_in(pad_in),
    .pin_val(pin_val), .pin_oe(pin_oe), .pin_rd(pin_rd), .fault_flags(fault_flags)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [NC-1:0] exp_oe(input logic [NP-1:0] en);
    logic [NC-1:0] r;
    for (int p = 0; p < NP; p++) begin r[2*p] = en[p]; r[2*p+1] = en[p]; end
    return r;
  endfunction

  function automatic logic [NC-1:0] exp_pins(input logic f, input logic [NC-1:0] pwm,
                                             input logic [NC-1:0] off);
    logic [NC-1:0] r;
    for (int c = 0; c < NC; c++) r[c] = f ? off[c] : pwm[c];
    return r;
  endfunction

  task automatic do_reset;
    rst_n = 0; fault_in = '0; flag_clr = '0; cnt_zero = 0; sw_restart = 0;
    tick; tick; rst_n = 1; tick;
  endtask

  initial begin
    do_reset;
    // Table walk: R2, R3, R4 and R1
    for (int k = 0; k < 6; k++) begin
      fault_in = TBL[k].f; pwm_in = TBL[k].pwm; off_val = TBL[k].off;
      pair_en = TBL[k].en; pad_in = TBL[k].pad;
      #1;
      chk("R2 pin value", 16'(pin_val), 16'(exp_pins(TBL[k].forced, TBL[k].pwm, TBL[k].off)));
      chk("R3 output enable", 16'(pin_oe), 16'(exp_oe(TBL[k].en)));
      chk("R4 readback", 16'((pin_val & exp_oe(TBL[k].en)) | (TBL[k].pad & ~exp_oe(TBL[k].en))),
          16'(pin_rd));
      tick;
    end

    // R10 reset state
    fault_in = '0; do_reset;
    pwm_in = 6'b110110; off_val = 6'b001001; pair_en = 3'b111;
    #1;
    chk("R10 flags after reset", 16'(fault_flags), 16'h0);
    chk("R10 pins follow pwm", 16'(pin_val), 16'(pwm_in));

    // R5 / R6 / R7 in automatic mode
    fault_in = 2'b01; #1;
    chk("R1 immediate off-level", 16'(pin_val), 16'(off_val));
    tick;
    chk("R5 flag set", 16'(fault_flags), 16'h1);
    flag_clr = 2'b01; tick; flag_clr = '0;
    chk("R6 clear ignored while fault high", 16'(fault_flags), 16'h1);
    fault_in = '0; tick;
    chk("R5 flag sticky", 16'(fault_flags), 16'h1);
    flag_clr = 2'b01; tick; flag_clr = '0;
    chk("R6 clear with fault low", 16'(fault_flags), 16'h0);
    tick;
    chk("R7 held until period start", 16'(pin_val), 16'(off_val));
    cnt_zero = 1; tick; cnt_zero = 0;
    chk("R7 released at period start", 16'(pin_val), 16'(pwm_in));

    // R8 software mode
    sw_restart = 1;
    fault_in = 2'b10; tick; fault_in = '0; tick;
    chk("R8 flag pending", 16'(fault_flags), 16'h2);
    cnt_zero = 1; tick; cnt_zero = 0;
    chk("R8 counter zero ignored", 16'(pin_val), 16'(off_val));
    flag_clr = 2'b10; tick; flag_clr = '0;
    chk("R8 still forced at clearing edge", 16'(pin_val), 16'(off_val));
    tick;
    chk("R8 released after flags clear", 16'(pin_val), 16'(pwm_in));

    // R9 fault while the clock is stopped (automatic mode)
    sw_restart = 0;
    clk_run = 0; #20;
    fault_in = 2'b01; #3;
    chk("R1 forced with clock stopped", 16'(pin_val), 16'(off_val));
    fault_in = '0; #3;
    chk("R9 stays forced after fault leaves", 16'(pin_val), 16'(off_val));
    #10; clk_run = 1;
    @(negedge clk); tick; tick;
    chk("R9 held after clock resumes", 16'(pin_val), 16'(off_val));
    cnt_zero = 1; tick; cnt_zero = 0;
    chk("R9 released by restart logic", 16'(pin_val), 16'(pwm_in));

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule